// File: doc/BRIEF.md
# Segmented Instruction Fetch Address Unit

This block holds a 16-bit code segment register and a 16-bit instruction pointer and turns them into a 20-bit physical fetch address. The address is the segment moved up by four bit positions plus the pointer. Any carry past the top address bit is dropped, so addresses wrap inside the 1 MB space. Fetch requests leave on a valid/ready handshake. When a request is accepted, memory returns the byte length of the fetched instruction on the same edge. The pointer then moves forward by that length and wraps inside its own 64 KB segment. The segment register does not change when fetches run in sequence.

Jumps load the segment and the pointer through two separate load strobes, and either one may be used alone. A pointer load wins over the sequential advance when both happen in the same cycle. A second combinational port applies the same segment-plus-offset mapping to an operand segment and offset for data accesses.

Back-pressure rules: `fetch_valid` follows `run` directly. While `fetch_valid` is high and `fetch_ready` is low, `fetch_addr` holds its value unless a jump load is applied. A transfer happens only on a rising clock edge where both signals are high. `fetch_len` is sampled only on that edge.

Top module: `seg_fetch_agu`

## Requirements
- R1: While reset is active and right after it, the segment register reads 16'hFFFF, the pointer reads 16'h0000 and `fetch_addr` reads 20'hFFFF0.
- R2: `fetch_addr` always equals (segment × 16 + pointer) modulo 2^20; for example segment FFFF with pointer FFFF gives 20'h0FFEF.
- R3: `data_addr` equals (`data_seg` × 16 + `data_off`) modulo 2^20, combinationally, with no dependence on the fetch state.
- R4: On an accepted fetch with `fetch_len` in 1..6 and no pointer load, the pointer becomes (pointer + `fetch_len`) modulo 2^16 at that edge. A 3-byte fetch at pointer 0000 leaves 0003, and FFFE plus 6 gives 0004 without touching the segment.
- R5: Without a segment load, the segment register keeps its value, including across accepted fetches.
- R6: With no accepted transfer (`fetch_valid` or `fetch_ready` low) and no pointer load, the pointer and `fetch_addr` hold their values.
- R7: A pointer load in the same cycle as an accepted fetch sets the pointer to the load value, and the fetch length is dropped.
- R8: The segment load and the pointer load are independent; each changes only its own register on the next edge.
- R9: An accepted fetch whose `fetch_len` is 0 or 7 leaves the pointer unchanged.
- R10: `fetch_valid` equals `run`; with `run` low, `fetch_ready` high does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables fetch requests |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_ready | input | 1 | Memory accepts the request |
| fetch_addr | output | 20 | Physical fetch address |
| fetch_len | input | 3 | Byte length of the accepted instruction |
| seg_ld | input | 1 | Load the code segment register |
| seg_ld_val | input | 16 | Segment load value |
| ptr_ld | input | 1 | Load the instruction pointer |
| ptr_ld_val | input | 16 | Pointer load value |
| code_seg | output | 16 | Current code segment register |
| instr_ptr | output | 16 | Current instruction pointer |
| data_seg | input | 16 | Operand segment for the data port |
| data_off | input | 16 | Operand offset for the data port |
| data_addr | output | 20 | Physical operand address |

## Verification
The bench builds the block with its default parameters: 16-bit segment and offset, a four-bit shift, a 20-bit address and a 3-bit length with a maximum of 6. With these widths, directed loads reach both wrap points: pointer overflow inside the segment, and address overflow past 1 MB. Random lengths cover the full 3-bit range, so the two ignored codes (0 and 7) appear alongside the valid ones. Random ready and load strobes also produce fetches that collide with jumps.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  localparam int unsigned SEG_W_DEF = 16;
  localparam int unsigned OFF_W_DEF = 16;
  localparam int unsigned SHIFT_DEF = 4;
  localparam int unsigned PA_W_DEF  = 20;
  localparam int unsigned LEN_W_DEF = 3;
  localparam int unsigned LEN_MAX_DEF = 6;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_LOAD = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
  parameter int unsigned SEG_W = seg_agu_pkg::SEG_W_DEF,
  parameter int unsigned OFF_W = seg_agu_pkg::OFF_W_DEF,
  parameter int unsigned SHIFT = seg_agu_pkg::SHIFT_DEF,
  parameter int unsigned PA_W  = seg_agu_pkg::PA_W_DEF
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  phys
);
  localparam int unsigned BASE_W = SEG_W + SHIFT;
  localparam int unsigned SUM_W  = (BASE_W > OFF_W ? BASE_W : OFF_W) + 1;

  logic [SUM_W-1:0] base_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  assign base_ext = SUM_W'({seg, {SHIFT{1'b0}}});
  assign off_ext  = SUM_W'(off);
  assign sum      = base_ext + off_ext;

  generate
    if (SUM_W > PA_W) begin : g_trunc
      assign phys = sum[PA_W-1:0];
    end else begin : g_ext
      assign phys = PA_W'(sum);
    end
  endgenerate
endmodule

// File: rtl/seg_base_reg.sv
module seg_base_reg #(
  parameter int unsigned SEG_W = seg_agu_pkg::SEG_W_DEF,
  parameter logic [SEG_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [SEG_W-1:0] ld_val,
  output logic [SEG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (ld) q <= ld_val;
  end

  a_r5_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));
  a_r8_seg_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val));
endmodule

// File: rtl/seg_ptr_reg.sv
module seg_ptr_reg #(
  parameter int unsigned OFF_W   = seg_agu_pkg::OFF_W_DEF,
  parameter int unsigned LEN_W   = seg_agu_pkg::LEN_W_DEF,
  parameter int unsigned LEN_MAX = seg_agu_pkg::LEN_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  input  logic             ld,
  input  logic [OFF_W-1:0] ld_val,
  output logic [OFF_W-1:0] q
);
  import seg_agu_pkg::*;

  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(LEN_MAX);

  logic    len_ok;
  ptr_op_e op;
  logic [OFF_W-1:0] step_val;

  assign len_ok   = (len != '0) && (len <= LEN_HI);
  assign step_val = q + OFF_W'(len);

  always_comb begin
    if (ld)                  op = PTR_LOAD;
    else if (fire && len_ok) op = PTR_STEP;
    else                     op = PTR_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else begin
      case (op)
        PTR_LOAD: q <= ld_val;
        PTR_STEP: q <= step_val;
        default:  q <= q;
      endcase
    end
  end

  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ld && len >= LEN_W'(1) && len <= LEN_HI)
      |=> q == $past(q) + OFF_W'($past(len)));
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val));
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !ld) |=> $stable(q));
  a_r9_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ld && (len == '0 || len > LEN_HI)) |=> $stable(q));
endmodule

// File: rtl/seg_fetch_agu.sv
module seg_fetch_agu #(
  parameter int unsigned SEG_W   = seg_agu_pkg::SEG_W_DEF,
  parameter int unsigned OFF_W   = seg_agu_pkg::OFF_W_DEF,
  parameter int unsigned SHIFT   = seg_agu_pkg::SHIFT_DEF,
  parameter int unsigned PA_W    = seg_agu_pkg::PA_W_DEF,
  parameter int unsigned LEN_W   = seg_agu_pkg::LEN_W_DEF,
  parameter int unsigned LEN_MAX = seg_agu_pkg::LEN_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [PA_W-1:0]  fetch_addr,
  input  logic [LEN_W-1:0] fetch_len,
  input  logic             seg_ld,
  input  logic [SEG_W-1:0] seg_ld_val,
  input  logic             ptr_ld,
  input  logic [OFF_W-1:0] ptr_ld_val,
  output logic [SEG_W-1:0] code_seg,
  output logic [OFF_W-1:0] instr_ptr,
  input  logic [SEG_W-1:0] data_seg,
  input  logic [OFF_W-1:0] data_off,
  output logic [PA_W-1:0]  data_addr
);
  localparam int unsigned LOW_W = (SHIFT < OFF_W) ? SHIFT : OFF_W;

  logic fire;

  assign fetch_valid = run;
  assign fire        = run & fetch_ready;

  seg_base_reg #(.SEG_W(SEG_W), .RST_VAL('1)) u_cs (
    .clk(clk), .rst_n(rst_n), .ld(seg_ld), .ld_val(seg_ld_val), .q(code_seg)
  );

  seg_ptr_reg #(.OFF_W(OFF_W), .LEN_W(LEN_W), .LEN_MAX(LEN_MAX)) u_ip (
    .clk(clk), .rst_n(rst_n), .fire(fire), .len(fetch_len),
    .ld(ptr_ld), .ld_val(ptr_ld_val), .q(instr_ptr)
  );

  seg_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_fetch_add (
    .seg(code_seg), .off(instr_ptr), .phys(fetch_addr)
  );

  seg_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_data_add (
    .seg(data_seg), .off(data_off), .phys(data_addr)
  );

  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r2_low_bits: assert (fetch_addr[LOW_W-1:0] == instr_ptr[LOW_W-1:0]);
      a_r3_data_low: assert (data_addr[LOW_W-1:0] == data_off[LOW_W-1:0]);
    end
  end

  a_r10_no_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ptr_ld) |=> $stable(instr_ptr));
  a_r6_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !ptr_ld && !seg_ld) |=> $stable(fetch_addr));
endmodule

// File: tb/seg_fetch_agu_test.sv
module seg_fetch_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [19:0] fetch_addr;
  logic [2:0]  fetch_len = 3'd0;
  logic        seg_ld = 1'b0;
  logic [15:0] seg_ld_val = 16'h0;
  logic        ptr_ld = 1'b0;
  logic [15:0] ptr_ld_val = 16'h0;
  logic [15:0] code_seg;
  logic [15:0] instr_ptr;
  logic [15:0] data_seg = 16'h0;
  logic [15:0] data_off = 16'h0;
  logic [19:0] data_addr;

  int unsigned total = 0;
  int unsigned bad = 0;
  logic [15:0] m_cs;
  logic [15:0] m_ip;
  int unsigned seed = 32'h5eed_0042;

  always #2.5 clk = ~clk;

  seg_fetch_agu uut (
    .clk(clk), .rst_n(rst_n), .run(run), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .fetch_len(fetch_len),
    .seg_ld(seg_ld), .seg_ld_val(seg_ld_val), .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val),
    .code_seg(code_seg), .instr_ptr(instr_ptr), .data_seg(data_seg),
    .data_off(data_off), .data_addr(data_addr)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return t[19:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " seg"}, 32'(code_seg), 32'(m_cs));
    chk({req, " ptr"}, 32'(instr_ptr), 32'(m_ip));
    chk({req, " R2 addr"}, 32'(fetch_addr), 32'(phys(m_cs, m_ip)));
    chk({req, " R10 valid"}, 32'(fetch_valid), 32'(run));
    chk({req, " R3 data"}, 32'(data_addr), 32'(phys(data_seg, data_off)));
  endtask

  // inputs already driven; advance one edge, update model, check at negedge
  task automatic step(input string req);
    #1;
    check_all({req, " pre"});
    @(posedge clk);
    if (seg_ld) m_cs = seg_ld_val;
    if (ptr_ld) m_ip = ptr_ld_val;
    else if (run && fetch_ready && fetch_len >= 3'd1 && fetch_len <= 3'd6)
      m_ip = m_ip + 16'(fetch_len);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic idle();
    run = 0; fetch_ready = 0; seg_ld = 0; ptr_ld = 0; fetch_len = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_cs = 16'hFFFF; m_ip = 16'h0000;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    chk("R1 reset addr", 32'(fetch_addr), 32'h000FFFF0);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after reset");

    // R8: segment load alone
    seg_ld = 1; seg_ld_val = 16'h2000; step("R8 seg only");
    chk("R8 ptr untouched", 32'(instr_ptr), 32'h0);
    idle();
    // R4: 3-byte fetch at 2000:0000
    run = 1; fetch_ready = 1; fetch_len = 3'd3;
    chk("R2 2000:0000", 32'(fetch_addr), 32'h00020000);
    step("R4 3-byte");
    chk("R4 ptr 0003", 32'(instr_ptr), 32'h3);
    chk("R5 seg kept", 32'(code_seg), 32'h2000);
    chk("R2 2000:0003", 32'(fetch_addr), 32'h00020003);
    // R6: back-pressure
    fetch_ready = 0; fetch_len = 3'd5; step("R6 stall");
    chk("R6 addr held", 32'(fetch_addr), 32'h00020003);
    // R10: run low, ready high
    run = 0; fetch_ready = 1; step("R10 no run");
    chk("R10 ptr held", 32'(instr_ptr), 32'h3);
    // R9: bad lengths
    run = 1; fetch_len = 3'd0; step("R9 len0");
    fetch_len = 3'd7; step("R9 len7");
    chk("R9 ptr held", 32'(instr_ptr), 32'h3);
    idle();
    // R2 wrap past 1 MB, R4 pointer wrap
    seg_ld = 1; seg_ld_val = 16'hFFFF; ptr_ld = 1; ptr_ld_val = 16'hFFFF; step("R8 both");
    chk("R2 wrap 0FFEF", 32'(fetch_addr), 32'h0000FFEF);
    idle();
    ptr_ld = 1; ptr_ld_val = 16'hFFFE; step("R8 ptr only");
    chk("R8 seg untouched", 32'(code_seg), 32'hFFFF);
    idle();
    run = 1; fetch_ready = 1; fetch_len = 3'd6; step("R4 wrap");
    chk("R4 ptr 0004", 32'(instr_ptr), 32'h4);
    chk("R5 seg no carry", 32'(code_seg), 32'hFFFF);
    // R7: load wins over fetch
    ptr_ld = 1; ptr_ld_val = 16'h1234; fetch_len = 3'd2; step("R7 collide");
    chk("R7 ptr 1234", 32'(instr_ptr), 32'h1234);
    idle();
    // R3 data port corners
    data_seg = 16'hFFFF; data_off = 16'hFFFF; #1;
    chk("R3 data wrap", 32'(data_addr), 32'h0000FFEF);
    data_seg = 16'h1000; data_off = 16'h0000; #1;
    chk("R3 data 10000", 32'(data_addr), 32'h00010000);
    @(negedge clk);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      run         = ($urandom % 4) != 0;
      fetch_ready = ($urandom % 3) != 0;
      fetch_len   = 3'($urandom);
      seg_ld      = ($urandom % 16) == 0;
      seg_ld_val  = 16'($urandom);
      ptr_ld      = ($urandom % 10) == 0;
      ptr_ld_val  = 16'($urandom);
      data_seg    = 16'($urandom);
      data_off    = 16'($urandom);
      step("R4 R5 R6 R7 R9 random");
    end
    idle();
    step("R6 final");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule